// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the station-management side of a PHY management link. Software writes one 32-bit command word that already holds every frame field: the start code, the operation code, the turnaround pair, the 5-bit PHY address, the 5-bit register address and the 16-bit data. The block then generates the management clock and shifts the complete frame out on the data pin. When the frame ends, it raises an event flag. For a read, the 16 bits returned by the PHY replace the low half of the same data register.

A separate speed register sets the management clock and the preamble. Its field at bits [DIV_W:1] is the half period of the management clock, counted in system clocks, so MDC runs at the system clock divided by twice that value. With the default `DIV_W` of 6 this field is bits [6:1]. The bit just above it drops the 32-bit preamble. A half-period value of (system clock in MHz + 2) / 5 keeps MDC at about 2.5 MHz or below. The value is zero after reset, which holds the interface idle until software programs a speed.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `mii_event` is 0 and `data_rdata` reads 0. The speed half-period is zero and the preamble is enabled.
- R2: An accepted command produces a frame made of 32 ones of preamble followed by command bits 31 down to 0, MSB first. The command fields are start at [31:30], operation at [29:28], PHY address at [27:23], register address at [22:18], turnaround at [17:16] and data at [15:0].
- R3: MDC idles low. Each frame bit is low for `H` system clocks and then high for `H` system clocks, where `H` is the speed field `spd_wdata[DIV_W:1]`. MDIO output and enable change only at MDC falling edges.
- R4: When the preamble-suppress bit `spd_wdata[DIV_W+1]` is 1, the 32 preamble bits are skipped and the frame starts at command bit 31.
- R5: For an operation code of 2'b10 (read), `mdio_oe` is low during the last 18 bit times, which are the turnaround and data bits. The block samples `mdio_i` at each of the 16 data-bit MDC rising edges and shifts it MSB first into `data_rdata[15:0]`. `data_rdata[31:16]` keeps the command.
- R6: For any other operation code, `mdio_oe` is high for every bit of the frame, and `data_rdata` holds the command word unchanged.
- R7: `mii_event` becomes 1 exactly 2·H·N system clocks after the command is accepted, where N is 64 bits, or 32 bits when the preamble is suppressed. From then on, `mdc` and `mdio_oe` are 0.
- R8: An `evt_we` pulse with `evt_w1c` = 1 clears `mii_event`. A pulse with `evt_w1c` = 0 leaves it unchanged. A frame ending in the same cycle as a clear leaves the flag set.
- R9: A command write issued while a frame is in progress is ignored. It changes neither `data_rdata` nor the frame, and it starts no further frame.
- R10: While the half-period is zero, a command write is ignored, `mdc` stays low and `mdio_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command/data register write strobe |
| cmd_wdata | input | 32 | Packed command word |
| data_rdata | output | 32 | Command/data register; read result in [15:0] |
| spd_we | input | 1 | Speed register write strobe |
| spd_wdata | input | DIV_W+1:1 | [DIV_W:1] half period, [DIV_W+1] preamble suppress |
| evt_we | input | 1 | Event register write strobe |
| evt_w1c | input | 1 | Write value for the event bit; 1 clears it |
| mii_event | output | 1 | Frame-complete event flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situation to reach is a command arriving in the middle of a live frame. The stimulus writes a second, different command word twenty cycles after the first one is accepted. The bench then checks that the register and the bit stream still match the first command, and that no further MDC edge appears after the event. Read capture needs a PHY stand-in. The stand-in watches MDC falling edges while the pin is released and presents the reply bits one by one. Every MDC rising edge is checked against a queue of expected bits, with released bits marked separately.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants for the management frame master.
// Assumes the fixed 32-bit command word and the 32-bit preamble of the
// management frame; only the clock divider width is a parameter.
package mdio_mgmt_pkg;
    localparam int CMD_W        = 32;
    localparam int PRE_LEN      = 32;
    localparam int FRAME_LEN    = PRE_LEN + CMD_W;
    localparam int DATA_W       = 16;
    localparam int RELEASE_BITS = DATA_W + 2;
    localparam int POS_W        = $clog2(FRAME_LEN);
    localparam int OP_HI        = 29;
    localparam int OP_LO        = 28;
    localparam logic [1:0] OP_READ = 2'b10;

    // True when a command word asks for a register read.
    function automatic logic cmd_is_read(input logic [CMD_W-1:0] w);
        return w[OP_HI:OP_LO] == OP_READ;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// Management clock generator.
// Toggles mdc every half_div system clocks while run is high and flags the
// edge about to happen with one-cycle strobes. Assumes half_div may change
// at any time; a count past a shortened limit expires on the next cycle.
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic             expire;

    // Half period ends when the counter reaches the programmed limit.
    assign expire   = run && (half_div != '0) && (cnt >= half_div - 1'b1);
    assign rise_stb = expire && !mdc;
    assign fall_stb = expire && mdc;

    // Divider counter and clock toggle; parked low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (expire) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else if (half_div != '0) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_sequencer.sv
// Frame bit sequencer.
// Walks a bit position through preamble and command, drives the data pin,
// releases it for the turnaround and data of a read, and requests a capture
// on each read-data rising edge. Assumes cmd_word[31:16] is stable while busy.
module mdio_sequencer
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pre_sup,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             rise_stb,
    input  logic             fall_stb,
    output logic             busy,
    output logic             done,
    output logic             cap_stb,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] CMD_START = POS_W'(PRE_LEN);
    localparam logic [POS_W-1:0] REL_START = POS_W'(FRAME_LEN - RELEASE_BITS);
    localparam logic [POS_W-1:0] CAP_START = POS_W'(FRAME_LEN - DATA_W);
    localparam int               IDX_W     = $clog2(CMD_W);

    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] bit_idx;
    logic             rd_op;
    logic             released;
    logic             bit_val;

    assign rd_op    = cmd_is_read(cmd_word);
    assign released = rd_op && (pos >= REL_START);
    assign bit_idx  = IDX_W'(CMD_W - 1) - pos[IDX_W-1:0];
    assign bit_val  = (pos < CMD_START) ? 1'b1 : cmd_word[bit_idx];
    assign done     = busy && fall_stb && (pos == LAST_POS);
    assign cap_stb  = busy && rise_stb && rd_op && (pos >= CAP_START);

    // Pin drive: only while a frame runs and the pin is not handed over.
    always_comb begin
        mdio_oe = busy && !released;
        mdio_o  = mdio_oe && bit_val;
    end

    // Bit position advances on every falling edge until the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pos  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            pos  <= pre_sup ? CMD_START : '0;
        end else if (done) begin
            busy <= 1'b0;
            pos  <= '0;
        end else if (busy && fall_stb) begin
            pos  <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_datareg.sv
// Command/data register.
// Loads the packed command on an accepted write and shifts captured read
// bits into the low half, MSB first. Assumes writes and captures never coincide.
module mdio_datareg
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] wdata,
    input  logic             cap_stb,
    input  logic             mdio_i,
    output logic [CMD_W-1:0] data_q
);
    // Load the command or shift one captured data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= wdata;
        end else if (cap_stb) begin
            data_q[DATA_W-1:0] <= {data_q[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
// Management frame master top.
// Holds the speed and event registers, accepts a command only when idle with
// a nonzero half period, and ties the clock generator, sequencer and data
// register together. Assumes an external tristate buffer built from mdio_o/oe.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      data_rdata,
    input  logic             spd_we,
    input  logic [DIV_W+1:1] spd_wdata,
    input  logic             evt_we,
    input  logic             evt_w1c,
    output logic             mii_event,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [DIV_W-1:0] half_div;
    logic             pre_sup;
    logic             accept;
    logic             seq_busy;
    logic             seq_done;
    logic             cap_stb;
    logic             rise_stb;
    logic             fall_stb;

    assign accept = cmd_we && !seq_busy && (half_div != '0);

    // Speed register: half period and preamble suppress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_div <= '0;
            pre_sup  <= 1'b0;
        end else if (spd_we) begin
            half_div <= spd_wdata[DIV_W:1];
            pre_sup  <= spd_wdata[DIV_W+1];
        end
    end

    // Event flag: set by frame end, cleared by writing a one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mii_event <= 1'b0;
        end else if (seq_done) begin
            mii_event <= 1'b1;
        end else if (evt_we && evt_w1c) begin
            mii_event <= 1'b0;
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_busy),
        .half_div (half_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_sequencer i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .pre_sup  (pre_sup),
        .cmd_word (data_rdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .busy     (seq_busy),
        .done     (seq_done),
        .cap_stb  (cap_stb),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_datareg i_dreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .wdata   (cmd_wdata),
        .cap_stb (cap_stb),
        .mdio_i  (mdio_i),
        .data_q  (data_rdata)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
// Property checker for the management frame master, bound to the top.
module mdio_mgmt_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        mii_event,
    input logic        cmd_we,
    input logic        evt_we,
    input logic        evt_w1c,
    input logic [31:0] data_rdata,
    input logic        busy,
    input logic        done
);
    p_pin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_release_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdio_oe) |-> (data_rdata[29:28] == 2'b10));

    p_event_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> mii_event);

    p_event_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_we && evt_w1c && !done) |=> !mii_event);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> $stable(data_rdata[31:16]));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .mii_event  (mii_event),
    .cmd_we     (cmd_we),
    .evt_we     (evt_we),
    .evt_w1c    (evt_w1c),
    .data_rdata (data_rdata),
    .busy       (seq_busy),
    .done       (seq_done)
);

// File: tb/test_mdio_mgmt_master.sv
// Scoreboard bench: the driver queues expected frame bits, the monitor
// checks each MDC rising edge against the queue and models the PHY reply.
module test_mdio_mgmt_master;
    localparam int DIV_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_we = 1'b0;
    logic [31:0]      cmd_wdata = '0;
    logic [31:0]      data_rdata;
    logic             spd_we = 1'b0;
    logic [DIV_W+1:1] spd_wdata = '0;
    logic             evt_we = 1'b0;
    logic             evt_w1c = 1'b0;
    logic             mii_event;
    logic             mdc;
    logic             mdio_o;
    logic             mdio_oe;
    logic             mdio_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int          exp_q[$];
    int          cur_div = 1;
    int          since_rise = -1;
    int          rel_cnt = 0;
    logic [15:0] phy_reply = '0;
    bit          in_frame = 1'b0;
    logic        prev_mdc = 1'b0;

    always #2 clk = ~clk;

    mdio_mgmt_master #(.DIV_W(DIV_W)) i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .data_rdata(data_rdata), .spd_we(spd_we), .spd_wdata(spd_wdata),
        .evt_we(evt_we), .evt_w1c(evt_w1c), .mii_event(mii_event),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected bit per MDC rise; PHY model on MDC falls.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc && !prev_mdc) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected MDC rise", 32'd1, 32'd0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e == 2)
                        check(!mdio_oe, "R5 pin released", {31'd0, mdio_oe}, 32'd0);
                    else
                        check(mdio_oe && (mdio_o == e[0]), "R2 frame bit",
                              {30'd0, mdio_oe, mdio_o}, {30'd0, 1'b1, e[0]});
                end
                if (since_rise >= 0)
                    check(since_rise == 2*cur_div - 1, "R3 MDC period",
                          since_rise + 1, 2*cur_div);
                since_rise = 0;
            end else if (since_rise >= 0) begin
                since_rise++;
            end
            if (!mdc && prev_mdc && in_frame && !mdio_oe && rel_cnt < 18) begin
                rel_cnt++;
                mdio_i = (rel_cnt >= 3) ? phy_reply[18 - rel_cnt] : 1'b0;
            end
        end
        prev_mdc = mdc;
    end

    task automatic set_speed(input int div, input bit sup);
        @(negedge clk);
        spd_wdata = {sup, DIV_W'(div)};
        spd_we = 1'b1;
        @(negedge clk);
        spd_we = 1'b0;
        cur_div = div;
    endtask

    // Driver: queue the frame, issue it, time the event, check the register.
    task automatic run_frame(input logic [31:0] cmd, input int div, input bit sup,
                             input logic [15:0] reply, input bit inject);
        bit rd;
        int nbits;
        int cyc;
        rd = (cmd[29:28] == 2'b10);
        set_speed(div, sup);
        phy_reply = reply;
        rel_cnt = 0;
        since_rise = -1;
        if (!sup) for (int i = 0; i < 32; i++) exp_q.push_back(1);
        for (int i = 31; i >= 0; i--) exp_q.push_back((rd && i <= 17) ? 2 : int'(cmd[i]));
        nbits = sup ? 32 : 64;
        @(negedge clk);
        cmd_wdata = cmd;
        cmd_we = 1'b1;
        in_frame = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        cyc = 0;
        while (!mii_event && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 20) begin
                cmd_wdata = ~cmd;
                cmd_we = 1'b1;
            end else begin
                cmd_we = 1'b0;
            end
        end
        in_frame = 1'b0;
        since_rise = -1;
        check(cyc == 2*div*nbits, sup ? "R4 R7 event timing" : "R7 event timing",
              cyc, 2*div*nbits);
        check(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
        exp_q.delete();
        if (rd)
            check(data_rdata == {cmd[31:16], reply}, "R5 read capture",
                  data_rdata, {cmd[31:16], reply});
        else
            check(data_rdata == cmd, inject ? "R9 busy write ignored" : "R6 write keeps command",
                  data_rdata, cmd);
        check(!mdc && !mdio_oe, "R7 idle after frame", {30'd0, mdc, mdio_oe}, 32'd0);
        if (inject) begin
            repeat (100) @(negedge clk);
            check(!mdc && !mdio_oe, "R9 no extra frame", {30'd0, mdc, mdio_oe}, 32'd0);
        end
        evt_w1c = 1'b0;
        evt_we = 1'b1;
        @(negedge clk);
        evt_we = 1'b0;
        check(mii_event, "R8 write 0 keeps event", {31'd0, mii_event}, 32'd1);
        evt_w1c = 1'b1;
        evt_we = 1'b1;
        @(negedge clk);
        evt_we = 1'b0;
        evt_w1c = 1'b0;
        check(!mii_event, "R8 write 1 clears event", {31'd0, mii_event}, 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!mdc && !mdio_oe && !mii_event, "R1 reset outputs",
              {29'd0, mdc, mdio_oe, mii_event}, 32'd0);
        check(data_rdata == 32'd0, "R1 reset data", data_rdata, 32'd0);

        // R10 zero half period: command ignored, pins quiet
        cmd_wdata = 32'h5A5A_1234;
        cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (40) @(negedge clk);
        check(!mdc && !mdio_oe && !mii_event, "R10 stays idle",
              {29'd0, mdc, mdio_oe, mii_event}, 32'd0);
        check(data_rdata == 32'd0, "R10 command ignored", data_rdata, 32'd0);

        // write frame with preamble (R2 R3 R6 R7)
        run_frame({2'b01, 2'b01, 5'h03, 5'h11, 2'b10, 16'hBEEF}, 2, 1'b0, 16'h0, 1'b0);
        // read frame, preamble suppressed (R4 R5)
        run_frame({2'b01, 2'b10, 5'h1F, 5'h02, 2'b11, 16'h0000}, 3, 1'b1, 16'hA5C3, 1'b0);
        // read with minimum divider and full preamble (R3 R5)
        run_frame({2'b01, 2'b10, 5'h00, 5'h1F, 2'b11, 16'hFFFF}, 1, 1'b0, 16'h8001, 1'b0);
        // write with a command injected mid-frame (R9)
        run_frame({2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'h6C39}, 5, 1'b1, 16'h0, 1'b1);
        // read with larger divider (R3 R5 R7)
        run_frame({2'b01, 2'b10, 5'h0C, 5'h05, 2'b11, 16'h1234}, 4, 1'b0, 16'h7E18, 1'b0);

        finish_run();
    end
endmodule